// File: doc/BRIEF.md
# Linked Command Chain DMA Walker

This block fetches a chain of command packets from main memory and streams their payload to a graphics command port. Every packet begins with a header word. The top byte of the header is the number of payload words that follow it. The low 24 bits point to the next header. The walker reads a header, reads and forwards its payload words one at a time, and then follows the link. It stops in one of three ways: at an end marker, when a revisited node is detected, or after too many nodes. When it stops, it writes the final pointer into its address register, clears its busy and active flags, and pulses an interrupt.

A transfer is started with a one-cycle `start` pulse that carries a control word and a head address. Only the linked-list control code starts a walk. Any other code is retired at once, with no memory traffic. Payload words leave on a valid/ready stream in memory order. The walker keeps only one memory read in flight at a time.

Top module: `cmd_chain_dma`

## Requirements
- R1: After reset, `ctrl_active`, `gfx_busy`, `irq`, `mem_req` and `cmd_valid` are 0, and `addr_reg`, `words_total` and `end_code` are 0. A `start` pulse while idle sets `ctrl_active` and loads `addr_reg` with `start_addr`. A `start` pulse while `ctrl_active` is 1 is ignored.
- R2: A start whose control word is not 32'h01000401 issues no memory read. One cycle later it pulses `irq` with `end_code` = 3, `words_total` = 0 and `addr_reg` equal to the start address.
- R3: Each header is read from the link pointer ANDed with 24'h1FFFFC. Payload word i (1-based) is read from (header address + 4*i) ANDed with 24'h1FFFFC, so payload reads wrap inside the 2 MiB window.
- R4: Header bits [31:24] give the payload count N. Exactly N payload words are forwarded on `cmd_data`, in the order they were read. Header words are never forwarded. `cmd_valid` and `cmd_data` hold steady while `cmd_ready` is low.
- R5: Header bits [23:0] are the next link. A link with bit 23 set ends the walk with `end_code` = 0, and that link is written to `addr_reg`.
- R6: Three remembered addresses are all initialised to 24'hFFFFFF: last, lower and not-lower. The walk stops with `end_code` = 1 and `addr_reg` = 24'hFFFFFF when a masked header address equals the lower or the not-lower entry. Otherwise the address goes into the lower entry if it is below last, or into the not-lower entry if not, and last is then set to it.
- R7: Before each node, if more than NODE_LIMIT nodes have already been walked, the walk stops with `end_code` = 2 and `addr_reg` = 24'hFFFFFF. This check comes before the loop check.
- R8: For a linked-list walk, `words_total` equals 1 plus one per header read plus the sum of the header payload counts.
- R9: On completion, `gfx_busy` clears and `addr_reg` takes the final pointer one cycle before `ctrl_active` clears. `irq` is a single-cycle pulse in the cycle that `ctrl_active` first reads 0.
- R10: `mem_req` and `mem_addr` stay steady until `mem_gnt`. No new request is issued until the previous read has returned on `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| start_ctrl | input | 32 | Control word for the transfer |
| start_addr | input | 24 | Head link address |
| ctrl_active | output | 1 | Transfer in progress (control enable bit) |
| gfx_busy | output | 1 | Graphics-side busy flag during a walk |
| addr_reg | output | 24 | Address register, written back on completion |
| words_total | output | 32 | Words consumed by the walk |
| end_code | output | 2 | 0 end marker, 1 loop, 2 node limit, 3 unsupported mode |
| irq | output | 1 | Completion interrupt pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Word-aligned byte address of the read |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Payload word available |
| cmd_data | output | 32 | Payload word |
| cmd_ready | input | 1 | Command port accepts the word |

## Verification
The assertions assume the memory side returns exactly one `mem_rvalid` beat for each granted request. They also assume that beat arrives only while the walker waits for it, at least one cycle after the grant. They assume `start` is a single-cycle pulse. The bench's memory responder keeps at most one read pending and picks a response delay of one to three cycles. It varies `mem_gnt` and `cmd_ready` by cycle position to create stalls. Every chain it builds lives at word-aligned locations that it wrote itself, apart from deliberately unwritten payload slots, which return a fixed pattern.

// File: rtl/cmd_chain_pkg.sv
package cmd_chain_pkg;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] WIN_MASK  = 24'h1F_FFFC;
  localparam logic [ADDR_W-1:0] NULL_LINK = 24'hFF_FFFF;
  localparam logic [DATA_W-1:0] LIST_MODE = 32'h0100_0401;

  typedef enum logic [1:0] {
    END_MARK    = 2'd0,
    END_LOOP    = 2'd1,
    END_LIMIT   = 2'd2,
    END_BADMODE = 2'd3
  } end_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HREQ,
    ST_HWAIT,
    ST_PREQ,
    ST_PWAIT,
    ST_PSEND,
    ST_CLOSE,
    ST_SIGNAL
  } walk_state_e;

  function automatic logic [ADDR_W-1:0] node_addr(input logic [ADDR_W-1:0] link);
    return link & WIN_MASK;
  endfunction

  function automatic logic [7:0] hdr_count(input logic [DATA_W-1:0] hdr);
    return hdr[31:24];
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_link(input logic [DATA_W-1:0] hdr);
    return hdr[23:0];
  endfunction

  function automatic logic link_ends(input logic [ADDR_W-1:0] link);
    return link[23];
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [7:0]        idx);
    logic [ADDR_W-1:0] offs;
    offs = {14'd0, idx, 2'b00};
    return (base + offs) & WIN_MASK;
  endfunction

endpackage

// File: rtl/cmd_chain_loop_guard.sv
module cmd_chain_loop_guard
  import cmd_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              commit,
  input  logic [ADDR_W-1:0] probe,
  output logic              hit
);

  logic [ADDR_W-1:0] last_q, lower_q, upper_q;
  logic              goes_lower;

  assign hit        = (probe == lower_q) || (probe == upper_q);
  assign goes_lower = probe < last_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      last_q  <= NULL_LINK;
      lower_q <= NULL_LINK;
      upper_q <= NULL_LINK;
    end else if (commit) begin
      if (goes_lower) lower_q <= probe;
      else            upper_q <= probe;
      last_q <= probe;
    end
  end

  // R6: the walker never records an address the guard flagged
  p_commit_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !hit);

endmodule

// File: rtl/cmd_chain_tally.sv
module cmd_chain_tally #(
  parameter int NODE_LIMIT = 2000000,
  parameter int TOTAL_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               seed,
  input  logic               add_en,
  input  logic [8:0]         add_words,
  input  logic               node_step,
  output logic [TOTAL_W-1:0] total,
  output logic               over_limit
);

  localparam int            NW       = $clog2(NODE_LIMIT + 2);
  localparam logic [NW-1:0] CAP      = NW'(NODE_LIMIT);
  localparam logic [NW-1:0] CAP_NEXT = NW'(NODE_LIMIT + 1);

  logic [NW-1:0] nodes_q;

  assign over_limit = nodes_q > CAP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total   <= '0;
      nodes_q <= '0;
    end else if (restart) begin
      total   <= TOTAL_W'(seed);
      nodes_q <= '0;
    end else begin
      if (add_en)    total   <= total + TOTAL_W'(add_words);
      if (node_step) nodes_q <= nodes_q + 1'b1;
    end
  end

  // R7: node count stops one past the cap
  p_node_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nodes_q <= CAP_NEXT);

  p_no_step_over_r7: assert property (@(posedge clk) disable iff (!rst_n)
    node_step |-> !over_limit);

endmodule

// File: rtl/cmd_chain_dma.sv
module cmd_chain_dma
  import cmd_chain_pkg::*;
#(
  parameter int NODE_LIMIT = 2000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_ctrl,
  input  logic [23:0] start_addr,
  output logic        ctrl_active,
  output logic        gfx_busy,
  output logic [23:0] addr_reg,
  output logic [31:0] words_total,
  output logic [1:0]  end_code,
  output logic        irq,
  output logic        mem_req,
  output logic [23:0] mem_addr,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        cmd_valid,
  output logic [31:0] cmd_data,
  input  logic        cmd_ready
);

  walk_state_e       state;
  logic [ADDR_W-1:0] link_q, cur_q, fin_ptr;
  end_kind_e         fin_code;
  logic [7:0]        pay_len, beat_idx;
  logic [DATA_W-1:0] beat_buf;

  // named internal events
  logic              start_take, list_mode;
  logic              hdr_arrive, beat_arrive, beat_leave;
  logic              node_accept, loop_hit, over_limit;
  logic              last_beat;
  logic [ADDR_W-1:0] probe;
  logic [7:0]        arr_count;
  logic [ADDR_W-1:0] arr_link;
  logic [8:0]        add_words;

  assign start_take  = start && (state == ST_IDLE);
  assign list_mode   = (start_ctrl == LIST_MODE);
  assign probe       = node_addr(link_q);
  assign hdr_arrive  = (state == ST_HWAIT) && mem_rvalid;
  assign beat_arrive = (state == ST_PWAIT) && mem_rvalid;
  assign beat_leave  = (state == ST_PSEND) && cmd_ready;
  assign last_beat   = (beat_idx == pay_len);
  assign node_accept = (state == ST_CHECK) && !over_limit && !loop_hit;
  assign arr_count   = hdr_count(mem_rdata);
  assign arr_link    = hdr_link(mem_rdata);
  assign add_words   = {1'b0, arr_count} + 9'd1;

  cmd_chain_loop_guard u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_take),
    .commit  (node_accept),
    .probe   (probe),
    .hit     (loop_hit)
  );

  cmd_chain_tally #(
    .NODE_LIMIT (NODE_LIMIT),
    .TOTAL_W    (32)
  ) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (start_take),
    .seed       (list_mode),
    .add_en     (hdr_arrive),
    .add_words  (add_words),
    .node_step  (node_accept),
    .total      (words_total),
    .over_limit (over_limit)
  );

  assign mem_req   = (state == ST_HREQ) || (state == ST_PREQ);
  assign mem_addr  = (state == ST_PREQ) ? beat_addr(cur_q, beat_idx) : cur_q;
  assign cmd_valid = (state == ST_PSEND);
  assign cmd_data  = beat_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      ctrl_active <= 1'b0;
      gfx_busy    <= 1'b0;
      addr_reg    <= '0;
      end_code    <= END_MARK;
      irq         <= 1'b0;
      link_q      <= '0;
      cur_q       <= '0;
      pay_len     <= '0;
      beat_idx    <= '0;
      beat_buf    <= '0;
      fin_ptr     <= '0;
      fin_code    <= END_MARK;
    end else begin
      irq <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            ctrl_active <= 1'b1;
            addr_reg    <= start_addr;
            link_q      <= start_addr;
            if (list_mode) begin
              gfx_busy <= 1'b1;
              state    <= ST_CHECK;
            end else begin
              end_code <= END_BADMODE;
              state    <= ST_SIGNAL;
            end
          end
        end
        ST_CHECK: begin
          if (over_limit) begin
            fin_ptr  <= NULL_LINK;
            fin_code <= END_LIMIT;
            state    <= ST_CLOSE;
          end else if (loop_hit) begin
            fin_ptr  <= NULL_LINK;
            fin_code <= END_LOOP;
            state    <= ST_CLOSE;
          end else begin
            cur_q <= probe;
            state <= ST_HREQ;
          end
        end
        ST_HREQ: if (mem_gnt) state <= ST_HWAIT;
        ST_HWAIT: begin
          if (mem_rvalid) begin
            pay_len  <= arr_count;
            link_q   <= arr_link;
            beat_idx <= 8'd1;
            if (arr_count != 8'd0) begin
              state <= ST_PREQ;
            end else if (link_ends(arr_link)) begin
              fin_ptr  <= arr_link;
              fin_code <= END_MARK;
              state    <= ST_CLOSE;
            end else begin
              state <= ST_CHECK;
            end
          end
        end
        ST_PREQ: if (mem_gnt) state <= ST_PWAIT;
        ST_PWAIT: begin
          if (mem_rvalid) begin
            beat_buf <= mem_rdata;
            state    <= ST_PSEND;
          end
        end
        ST_PSEND: begin
          if (cmd_ready) begin
            if (!last_beat) begin
              beat_idx <= beat_idx + 8'd1;
              state    <= ST_PREQ;
            end else if (link_ends(link_q)) begin
              fin_ptr  <= link_q;
              fin_code <= END_MARK;
              state    <= ST_CLOSE;
            end else begin
              state <= ST_CHECK;
            end
          end
        end
        ST_CLOSE: begin
          gfx_busy <= 1'b0;
          addr_reg <= fin_ptr;
          end_code <= fin_code;
          state    <= ST_SIGNAL;
        end
        ST_SIGNAL: begin
          ctrl_active <= 1'b0;
          irq         <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: request held with a steady address until granted
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R10: read data only arrives while a read is outstanding
  p_rvalid_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (state == ST_HWAIT) || (state == ST_PWAIT));

  // R3: every read address is word aligned inside the window
  p_mem_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00) && (mem_addr[23:21] == 3'b000));

  // R4: stalled payload word does not change
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  // R9: interrupt is a single-cycle pulse
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9: interrupt only after busy and active have both dropped
  p_irq_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ctrl_active && !gfx_busy);

  // R9: active falls exactly when the interrupt fires
  p_active_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_active) |-> irq);

  // R1: busy never stands without an active transfer
  p_busy_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_busy |-> ctrl_active);

endmodule

// File: tb/cmd_chain_dma_tb.sv
`timescale 1ns/1ps
module cmd_chain_dma_tb;

  localparam int LIMIT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_ctrl = '0;
  logic [23:0] start_addr = '0;
  logic        ctrl_active, gfx_busy, irq, mem_req, cmd_valid;
  logic [23:0] addr_reg, mem_addr;
  logic [31:0] words_total, cmd_data;
  logic [1:0]  end_code;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0, cmd_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  cmd_chain_dma #(.NODE_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ctrl(start_ctrl),
    .start_addr(start_addr), .ctrl_active(ctrl_active), .gfx_busy(gfx_busy),
    .addr_reg(addr_reg), .words_total(words_total), .end_code(end_code),
    .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int stall_mode = 0;
  int irq_count = 0;

  logic [31:0] memw [int];
  int          exp_rd[$];
  logic [31:0] exp_out[$];
  int          exp_total, exp_ptr, exp_code;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input int a);
    if (memw.exists(a)) return memw[a];
    return 32'h5A00_0000 ^ a;
  endfunction

  // behavioural reference: walk the chain with integers and queues
  task automatic run_model(input logic [31:0] ctrl, input int sa);
    int p, a, h, n, cnt, last, lo, hi;
    exp_rd.delete();
    exp_out.delete();
    if (ctrl != 32'h0100_0401) begin
      exp_code = 3; exp_total = 0; exp_ptr = sa;
      return;
    end
    p = sa; exp_total = 1; cnt = 0;
    last = 'hFFFFFF; lo = 'hFFFFFF; hi = 'hFFFFFF;
    forever begin
      a = p & 'h1FFFFC;
      if (cnt > LIMIT) begin exp_code = 2; exp_ptr = 'hFFFFFF; break; end
      cnt++;
      if (a == lo || a == hi) begin exp_code = 1; exp_ptr = 'hFFFFFF; break; end
      if (a < last) lo = a; else hi = a;
      last = a;
      exp_rd.push_back(a);
      h = rd(a);
      n = (h >> 24) & 'hFF;
      exp_total += n + 1;
      for (int i = 1; i <= n; i++) begin
        int b;
        b = (a + 4 * i) & 'h1FFFFC;
        exp_rd.push_back(b);
        exp_out.push_back(rd(b));
      end
      p = h & 'hFFFFFF;
      if (p & 'h800000) begin exp_code = 0; exp_ptr = p; break; end
    end
  endtask

  // memory responder and per-clock comparison against the model
  int          pend_cnt = 0;
  int          pend_addr = 0;
  logic        prev_active = 0, prev_busy = 0, prev_cv = 0, prev_rdy = 0;
  logic [23:0] prev_addr = '0;
  logic [31:0] prev_data = '0;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (stall_mode == 0) begin
        mem_gnt = 1'b1; cmd_ready = 1'b1;
      end else begin
        mem_gnt = (cyc % 3) != 0; cmd_ready = (cyc % 4) < 2;
      end
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          mem_rvalid = 1'b1; mem_rdata = rd(pend_addr);
        end else mem_rvalid = 1'b0;
      end else mem_rvalid = 1'b0;
      if (rst_n) begin
        if (mem_req && mem_gnt) begin
          chk(pend_cnt == 0 && !mem_rvalid, "R10 one read outstanding", pend_cnt, 0);
          if (exp_rd.size() == 0) chk(0, "R3 unexpected read", mem_addr, 0);
          else begin
            chk(mem_addr == 24'(exp_rd[0]), "R3 read address", mem_addr, exp_rd[0]);
            void'(exp_rd.pop_front());
          end
          pend_addr = int'(mem_addr);
          pend_cnt = (stall_mode == 0) ? 1 : 1 + (cyc % 3);
        end
        if (prev_cv && !prev_rdy)
          chk(cmd_valid && cmd_data == prev_data, "R4 stalled word held", cmd_data, prev_data);
        if (cmd_valid && cmd_ready) begin
          if (exp_out.size() == 0) chk(0, "R4 unexpected payload", cmd_data, 0);
          else begin
            chk(cmd_data == exp_out[0], "R4 payload word", cmd_data, exp_out[0]);
            void'(exp_out.pop_front());
          end
        end
        if (irq) begin
          irq_count++;
          chk(prev_active && !ctrl_active, "R9 active falls with irq", ctrl_active, 0);
          chk(!prev_busy, "R9 busy cleared before irq", prev_busy, 0);
          chk(prev_addr == 24'(exp_ptr), "R9 pointer written before irq", prev_addr, exp_ptr);
        end
      end
      prev_active = ctrl_active; prev_busy = gfx_busy; prev_addr = addr_reg;
      prev_cv = cmd_valid; prev_rdy = cmd_ready; prev_data = cmd_data;
    end
  end

  task automatic run_case(input string name, input logic [31:0] ctrl, input int sa,
                          input int mode, input bit poke);
    int t;
    int irq0;
    stall_mode = mode;
    run_model(ctrl, sa);
    irq0 = irq_count;
    @(negedge clk);
    start = 1'b1; start_ctrl = ctrl; start_addr = 24'(sa);
    @(negedge clk);
    start = 1'b0;
    chk(ctrl_active == 1'b1, "R1 active after start", ctrl_active, 1);
    chk(addr_reg == 24'(sa), "R1 address loaded", addr_reg, sa);
    t = 0;
    while (irq_count == irq0 && t < 20000) begin
      @(negedge clk);
      t++;
      if (poke && t == 6) begin
        start = 1'b1; start_ctrl = 32'h0100_0201; start_addr = 24'h000123;
      end else start = 1'b0;
    end
    repeat (3) @(negedge clk);
    $display("case %s done", name);
    chk(irq_count == irq0 + 1, "R9 single interrupt", irq_count - irq0, 1);
    chk(end_code == 2'(exp_code), "R5 R6 R7 R2 end code", end_code, exp_code);
    chk(words_total == 32'(exp_total), "R8 words total", words_total, exp_total);
    chk(addr_reg == 24'(exp_ptr), "R5 final pointer", addr_reg, exp_ptr);
    chk(exp_rd.size() == 0, "R3 all reads issued", exp_rd.size(), 0);
    chk(exp_out.size() == 0, "R4 all payload forwarded", exp_out.size(), 0);
    chk(!ctrl_active && !gfx_busy, "R9 idle after end", {ctrl_active, gfx_busy}, 0);
  endtask

  initial begin
    int w;
    w = 0;
    forever begin
      @(posedge clk);
      w++;
      if (w > 150000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<150000", w);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    // chains
    memw[32'h0100] = 32'h00FF_FFFF;
    memw[32'h1000] = 32'h0300_2000;
    memw[32'h1004] = 32'h1111_0001; memw[32'h1008] = 32'h2222_0002;
    memw[32'h100C] = 32'h3333_0003;
    memw[32'h2000] = 32'h0000_3000;
    memw[32'h3000] = 32'h0280_1234;
    memw[32'h3004] = 32'hAAAA_0004; memw[32'h3008] = 32'hBBBB_0005;
    memw[32'h0010] = 32'h013F_FFF6; memw[32'h0014] = 32'hC0DE_0006;
    memw[32'h1FFFF4] = 32'h001F_FFF8;
    memw[32'h1FFFF8] = 32'h02C0_0000; memw[32'h1FFFFC] = 32'hE0D0_0007;
    memw[32'h4000] = 32'h0100_5000; memw[32'h4004] = 32'h4444_0008;
    memw[32'h5000] = 32'h0000_4000;
    for (int k = 0; k < 10; k++)
      memw[32'h6000 + 16 * k] = (k == 9) ? 32'h00FF_FFFF : 32'h0000_6000 + 16 * (k + 1);
    for (int k = 0; k < 7; k++)
      memw[32'h7000 + 16 * k] = (k == 6) ? 32'h00FF_FFFF : 32'h0000_7000 + 16 * (k + 1);
    memw[32'h8000] = 32'hFF80_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!ctrl_active && !gfx_busy && !irq, "R1 reset flags", {ctrl_active, gfx_busy, irq}, 0);
    chk(!mem_req && !cmd_valid, "R1 reset handshakes", {mem_req, cmd_valid}, 0);
    chk(addr_reg == 0 && words_total == 0 && end_code == 0, "R1 reset registers",
        addr_reg, 0);

    run_case("single",   32'h0100_0401, 'h0100,   0, 0); // R5 R8
    run_case("three",    32'h0100_0401, 'h1000,   0, 0); // R4 R5 R8
    run_case("three_st", 32'h0100_0401, 'h1000,   1, 0); // R4 R10 stalls
    run_case("window",   32'h0100_0401, 'hE00013, 1, 0); // R3 wrap
    run_case("loop",     32'h0100_0401, 'h4000,   0, 0); // R6
    run_case("limit",    32'h0100_0401, 'h6000,   1, 0); // R7 abort
    run_case("at_limit", 32'h0100_0401, 'h7000,   0, 0); // R7 boundary
    run_case("badmode",  32'h0100_0201, 'h0100,   0, 0); // R2
    run_case("ignored",  32'h0100_0401, 'h1000,   1, 1); // R1 restart ignored
    run_case("long",     32'h0100_0401, 'h8000,   0, 0); // R4 255 words

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule